// File: doc/BRIEF.md
# Double-Buffered Merging Write Buffer

This block sits between one bus port and a memory back end. It collects byte, halfword and word writes into eight words of storage, organised as two four-word halves. At any time one half is the merge target. It records each incoming byte together with a per-byte valid bit. The other half can meanwhile stream its contents to memory as a four-beat burst, and the per-byte valid bits go out as beat byte enables, so bytes that were never written are left unchanged in memory.

A half is written back in four cases:
- a write arrives for a different quad word, and the two halves swap roles;
- a read targets the quad word being merged;
- an idle countdown, restarted by every write, runs out;
- the enable input is low.

A read of a quad word that is held in the buffer waits until that quad's burst is complete. Any other read goes straight to the memory read port. Apart from timing, the buffering cannot be observed.

Top module: `wbuf_merge`

## Requirements
- R1: After reset, no burst is in progress (`mem_wr_valid_o` low), `wr_ready_o` is high, and with no read request `mem_rd_valid_o` is low.
- R2: Writes to one quad word (byte address bits [15:4]) merge per byte into the active half, including non-contiguous writes. The burst for a half has four beats at addresses quad base + 0, 4, 8 and 12. Each beat carries byte enable bit k set only for bytes written at that word (strobe bit k covers data bits [8k+7:8k]). `mem_wr_last_o` is high on the fourth beat only.
- R3: A write to a different quad word, while the other half is idle, is accepted in the cycle it is presented. The previously active half starts its burst on the next cycle.
- R4: A write to a different quad word while the other half is still draining is stalled: `wr_ready_o` stays low until that burst completes.
- R5: A read whose quad word is held in the buffer (merging or draining) is not forwarded to memory until the burst for that quad has finished.
- R6: A read to any other quad word is forwarded in the same cycle: `mem_rd_valid_o` follows `rd_valid_i`, `mem_rd_addr_o` equals `rd_addr_i`, and `rd_ready_o` follows `mem_rd_ready_i`.
- R7: Each accepted write reloads an idle countdown with `timeout_i`. If no further write arrives, the burst of the active half starts `timeout_i`+1 cycles after the clock edge that accepted the last write.
- R8: In a cycle where a flush of the active half is pending, a write is stalled, even when it targets the same quad word. That write is then merged into the other half and does not appear in the flushed burst.
- R9: While `enable_i` is low, a filled active half starts its burst on the next cycle.
- R10: Once the last beat of a burst is accepted, that half holds nothing. A read of its quad word is then forwarded at once.
- R11: While `mem_wr_valid_o` is high and `mem_wr_ready_i` is low, the beat address, data and byte enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Buffering enable; low forces write-back |
| timeout_i | input | 8 | Idle countdown reload value |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write accepted this cycle |
| wr_addr_i | input | 16 | Write byte address |
| wr_data_i | input | 32 | Write data |
| wr_strb_i | input | 4 | Write byte strobes |
| rd_valid_i | input | 1 | Read request |
| rd_ready_o | output | 1 | Read accepted by memory this cycle |
| rd_addr_i | input | 16 | Read byte address |
| mem_rd_valid_o | output | 1 | Read request to memory |
| mem_rd_ready_i | input | 1 | Memory accepts read |
| mem_rd_addr_o | output | 16 | Read address to memory |
| mem_wr_valid_o | output | 1 | Burst beat valid |
| mem_wr_ready_i | input | 1 | Memory accepts beat |
| mem_wr_addr_o | output | 16 | Beat byte address |
| mem_wr_data_o | output | 32 | Beat data |
| mem_wr_be_o | output | 4 | Beat byte enables |
| mem_wr_last_o | output | 1 | Final beat of burst |

## Verification
A write to the merging quad word can arrive in the same cycle that the idle countdown reaches zero. The merge and the timed flush then compete for the same half. The bench provokes this by loading a timeout of three and presenting a second write to the same quad exactly three cycles after the first write was accepted. It then checks three things: `wr_ready_o` is low in that cycle, the flushed burst carries only the first write's byte enables, and the late write appears in the following burst from the other half.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WB_HALVES = 2;
  typedef logic [0:0] half_idx_t;
endpackage

// File: rtl/wbuf_half.sv
module wbuf_half #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned BE_W   = DATA_W / 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned TAG_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    load_i,
  input  logic                    clr_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [BE_W-1:0]         strb_i,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [BEATS*BE_W-1:0]   mask_o,
  output logic [BEATS*DATA_W-1:0] data_o
);
  logic                    valid_q;
  logic [TAG_W-1:0]        tag_q;
  logic [BEATS*BE_W-1:0]   mask_q, mask_d;
  logic [BEATS*DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    mask_d = mask_q;
    if (clr_i) mask_d = '0;
    if (wr_en_i) begin
      if (load_i) mask_d = '0;
      for (int k = 0; k < int'(BE_W); k++) begin
        if (strb_i[k]) begin
          data_d[int'(sel_i)*DATA_W + k*8 +: 8] = data_i[k*8 +: 8];
          mask_d[int'(sel_i)*BE_W + k]          = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else begin
      mask_q <= mask_d;
      data_q <= data_d;
      if (wr_en_i && load_i) tag_q <= tag_i;
      if (clr_i) valid_q <= 1'b0;
      else if (wr_en_i) valid_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;

  // a cleared half must hold no byte marks on the following cycle
  p_clear_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !wr_en_i |=> !valid_o && (mask_o == '0));
endmodule

// File: rtl/wbuf_timer.sv
module wbuf_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             stop_i,
  output logic             expired_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      cnt_q   <= val_i;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);

  // expiry persists until serviced or restarted
  p_expiry_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_i && !stop_i |=> expired_o);
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned TMR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [TMR_W-1:0]  timeout_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W/8-1:0] wr_strb_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic [DATA_W/8-1:0] mem_wr_be_o,
  output logic              mem_wr_last_o
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned WOFF  = $clog2(BE_W);
  localparam int unsigned SEL_W = $clog2(BEATS);
  localparam int unsigned QOFF  = WOFF + SEL_W;
  localparam int unsigned TAG_W = ADDR_W - QOFF;

  half_idx_t        act_q, drain_idx_q, wr_tgt;
  logic             drain_busy_q;
  logic [SEL_W-1:0] beat_q;

  logic                    h_valid [WB_HALVES];
  logic [TAG_W-1:0]        h_tag   [WB_HALVES];
  logic [BEATS*BE_W-1:0]   h_mask  [WB_HALVES];
  logic [BEATS*DATA_W-1:0] h_data  [WB_HALVES];

  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [SEL_W-1:0] wr_sel;
  logic act_valid, wr_miss, rd_hit_act, rd_blk, tmr_exp;
  logic flush_req, wr_fire, drain_start, beat_acc, drain_done;
  logic unused_wr_low;

  assign wr_tag        = wr_addr_i[ADDR_W-1:QOFF];
  assign wr_sel        = wr_addr_i[QOFF-1:WOFF];
  assign rd_tag        = rd_addr_i[ADDR_W-1:QOFF];
  assign unused_wr_low = ^wr_addr_i[WOFF-1:0];

  assign act_valid  = h_valid[act_q];
  assign wr_miss    = act_valid && (h_tag[act_q] != wr_tag);
  assign rd_hit_act = act_valid && (h_tag[act_q] == rd_tag);
  assign rd_blk     = rd_hit_act || (drain_busy_q && h_tag[drain_idx_q] == rd_tag);

  // flush of the active half for any reason other than a write miss
  assign flush_req   = act_valid && (!enable_i || tmr_exp || (rd_valid_i && rd_hit_act));
  assign wr_ready_o  = !flush_req && !(wr_miss && drain_busy_q);
  assign wr_fire     = wr_valid_i && wr_ready_o;
  assign drain_start = (wr_fire && wr_miss) || (flush_req && !drain_busy_q);
  assign wr_tgt      = drain_start ? ~act_q : act_q;
  assign beat_acc    = mem_wr_valid_o && mem_wr_ready_i;
  assign drain_done  = beat_acc && mem_wr_last_o;

  for (genvar g = 0; g < WB_HALVES; g++) begin : g_half
    wbuf_half #(
      .DATA_W(DATA_W), .BEATS(BEATS), .BE_W(BE_W), .SEL_W(SEL_W), .TAG_W(TAG_W)
    ) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_fire && (wr_tgt == half_idx_t'(g))),
      .load_i  (!h_valid[g]),
      .clr_i   (drain_done && (drain_idx_q == half_idx_t'(g))),
      .tag_i   (wr_tag),
      .sel_i   (wr_sel),
      .data_i  (wr_data_i),
      .strb_i  (wr_strb_i),
      .valid_o (h_valid[g]),
      .tag_o   (h_tag[g]),
      .mask_o  (h_mask[g]),
      .data_o  (h_data[g])
    );
  end

  wbuf_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_fire),
    .val_i     (timeout_i),
    .stop_i    (drain_start),
    .expired_o (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q        <= '0;
      drain_idx_q  <= '0;
      drain_busy_q <= 1'b0;
      beat_q       <= '0;
    end else if (drain_start) begin
      drain_busy_q <= 1'b1;
      drain_idx_q  <= act_q;
      beat_q       <= '0;
      act_q        <= ~act_q;
    end else if (beat_acc) begin
      beat_q <= beat_q + 1'b1;
      if (mem_wr_last_o) drain_busy_q <= 1'b0;
    end
  end

  assign mem_wr_valid_o = drain_busy_q;
  assign mem_wr_addr_o  = {h_tag[drain_idx_q], beat_q, {WOFF{1'b0}}};
  assign mem_wr_data_o  = h_data[drain_idx_q][int'(beat_q)*DATA_W +: DATA_W];
  assign mem_wr_be_o    = h_mask[drain_idx_q][int'(beat_q)*BE_W +: BE_W];
  assign mem_wr_last_o  = drain_busy_q && (beat_q == SEL_W'(BEATS-1));

  assign mem_rd_valid_o = rd_valid_i && !rd_blk;
  assign rd_ready_o     = mem_rd_ready_i && !rd_blk;
  assign mem_rd_addr_o  = rd_addr_i;

  p_beat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && !mem_wr_ready_i |=> mem_wr_valid_o && $stable(mem_wr_addr_o)
      && $stable(mem_wr_data_o) && $stable(mem_wr_be_o));

  p_miss_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && wr_valid_i && act_valid && (h_tag[act_q] != wr_tag) |-> !wr_ready_o);

  p_read_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !(mem_wr_valid_o &&
      mem_wr_addr_o[ADDR_W-1:QOFF] == mem_rd_addr_o[ADDR_W-1:QOFF]));

  p_disable_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && act_valid && !mem_wr_valid_o |=> mem_wr_valid_o);

  p_idle_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done |=> !mem_wr_valid_o);

  p_last_in_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_last_o |-> mem_wr_valid_o);
endmodule

// File: tb/wbuf_merge_tb_top.sv
`timescale 1ns/1ps
module wbuf_merge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [7:0]  timeout = 8'd200;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_addr = '0;
  logic        mrd_valid;
  logic        mrd_ready = 1'b1;
  logic [15:0] mrd_addr;
  logic        mwr_valid;
  logic        mwr_ready = 1'b1;
  logic [15:0] mwr_addr;
  logic [31:0] mwr_data;
  logic [3:0]  mwr_be;
  logic        mwr_last;

  int n_chk = 0;
  int n_bad = 0;
  int nlog  = 0;
  logic [15:0] log_addr [32];
  logic [31:0] log_data [32];
  logic [3:0]  log_be   [32];
  logic        log_last [32];

  always #10 clk = ~clk;

  wbuf_merge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .timeout_i(timeout),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_addr_i(rd_addr),
    .mem_rd_valid_o(mrd_valid), .mem_rd_ready_i(mrd_ready), .mem_rd_addr_o(mrd_addr),
    .mem_wr_valid_o(mwr_valid), .mem_wr_ready_i(mwr_ready), .mem_wr_addr_o(mwr_addr),
    .mem_wr_data_o(mwr_data), .mem_wr_be_o(mwr_be), .mem_wr_last_o(mwr_last)
  );

  // beat log: handshake seen before the next rising edge
  always @(negedge clk) begin
    #2;
    if (mwr_valid && mwr_ready && nlog < 32) begin
      log_addr[nlog] = mwr_addr;
      log_data[nlog] = mwr_data;
      log_be[nlog]   = mwr_be;
      log_last[nlog] = mwr_last;
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    for (int i = 0; i < 300 && nlog < n; i++) @(negedge clk);
    #3;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    for (int i = 0; i < 300 && mwr_valid; i++) begin @(negedge clk); #1; end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 burst idle", 32'(mwr_valid), 32'd0);
    chk("R1 write ready", 32'(wr_ready), 32'd1);
    chk("R1 read idle", 32'(mrd_valid), 32'd0);
  endtask

  task automatic t_merge();
    nlog = 0;
    do_wr(16'h0101, 32'h0000AA00, 4'b0010);
    do_wr(16'h010A, 32'h12340000, 4'b1100);
    do_wr(16'h010C, 32'hCAFEF00D, 4'b1111);
    @(negedge clk); #1;
    chk("R2 no early burst", 32'(mwr_valid), 32'd0);
    wr_valid = 1'b1; wr_addr = 16'h0200; wr_data = 32'h11111111; wr_strb = 4'hF;
    #1;
    chk("R3 miss accepted at once", 32'(wr_ready), 32'd1);
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
    #1;
    chk("R3 old half draining", 32'(mwr_valid), 32'd1);
    wait_beats(4);
    chk("R2 beats", nlog, 4);
    chk("R2 addr0", 32'(log_addr[0]), 32'h0100);
    chk("R2 be0", 32'(log_be[0]), 32'h2);
    chk("R2 data0", log_data[0] & 32'h0000FF00, 32'h0000AA00);
    chk("R2 addr1", 32'(log_addr[1]), 32'h0104);
    chk("R2 be1", 32'(log_be[1]), 32'h0);
    chk("R2 be2", 32'(log_be[2]), 32'hC);
    chk("R2 data2", log_data[2] & 32'hFFFF0000, 32'h12340000);
    chk("R2 addr3", 32'(log_addr[3]), 32'h010C);
    chk("R2 data3", log_data[3], 32'hCAFEF00D);
    chk("R2 last", {log_last[0], log_last[1], log_last[2], log_last[3]}, 32'b0001);
  endtask

  task automatic t_stall();
    wait_idle();
    nlog = 0;
    mwr_ready = 1'b0;
    do_wr(16'h0300, 32'h33333333, 4'hF);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h0400; wr_data = 32'h44444444; wr_strb = 4'hF;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R4 miss stalled during drain", 32'(wr_ready), 32'd0);
      chk("R11 beat held", 32'(mwr_addr), 32'h0200);
      @(negedge clk);
    end
    mwr_ready = 1'b1;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
    wait_beats(8);
    chk("R4 first burst addr", 32'(log_addr[0]), 32'h0200);
    chk("R4 first burst data", log_data[0], 32'h11111111);
    chk("R4 second burst addr", 32'(log_addr[4]), 32'h0300);
  endtask

  task automatic t_read();
    wait_idle();
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 16'h0500;
    #1;
    chk("R6 miss forwarded", 32'(mrd_valid), 32'd1);
    chk("R6 addr", 32'(mrd_addr), 32'h0500);
    chk("R6 ready", 32'(rd_ready), 32'd1);
    @(negedge clk);
    nlog = 0;
    rd_addr = 16'h0404;
    #1;
    chk("R5 hit held", 32'(mrd_valid), 32'd0);
    for (int i = 0; i < 50 && !mrd_valid; i++) begin @(negedge clk); #1; end
    chk("R5 burst done first", nlog, 4);
    chk("R5 burst addr", 32'(log_addr[0]), 32'h0400);
    chk("R10 read forwarded after clear", 32'(mrd_valid), 32'd1);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic t_timer();
    int n;
    wait_idle();
    timeout = 8'd5;
    do_wr(16'h0600, 32'h66666666, 4'hF);
    repeat (3) @(negedge clk);
    do_wr(16'h0604, 32'h77777777, 4'hF);
    n = 0;
    #1;
    for (int i = 0; i < 40 && !mwr_valid; i++) begin @(negedge clk); #1; n++; end
    chk("R7 flush delay after restart", n, 6);
  endtask

  task automatic t_collide();
    wait_idle();
    wait_beats(0);
    nlog = 0;
    timeout = 8'd3;
    do_wr(16'h0700, 32'hA0A0A0A0, 4'hF);
    repeat (3) @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h0704; wr_data = 32'hB0B0B0B0; wr_strb = 4'hF;
    #1;
    chk("R8 write stalled on expiry", 32'(wr_ready), 32'd0);
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
    wait_beats(8);
    chk("R8 first burst be0", 32'(log_be[0]), 32'hF);
    chk("R8 late write excluded", 32'(log_be[1]), 32'h0);
    chk("R8 late write addr", 32'(log_addr[5]), 32'h0704);
    chk("R8 late write be", 32'(log_be[5]), 32'hF);
    chk("R8 late write data", log_data[5], 32'hB0B0B0B0);
  endtask

  task automatic t_disable();
    wait_idle();
    timeout = 8'd200;
    do_wr(16'h0800, 32'h88888888, 4'hF);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 held while enabled", 32'(mwr_valid), 32'd0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk); #1;
    chk("R9 flush on disable", 32'(mwr_valid), 32'd1);
    chk("R9 flush addr", 32'(mwr_addr), 32'h0800);
    wait_idle();
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_merge();
    t_stall();
    t_read();
    t_timer();
    t_collide();
    t_disable();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule